// File: doc/BRIEF.md
# Two-Client Guarded FIFO

This block puts a synchronous first-in first-out store behind a guarded method interface shared by several clients (two by default). Each client has three methods: enqueue, dequeue and head read. Each method shows a ready output. A client uses a method by raising that method's enable while its ready is high. The ready outputs tell a client, in the same cycle, whether its enable would take effect. A client that sees ready low keeps its request up and tries again in the next cycle.

Inside, a small storage core uses active-low push and pop strobes and an active-low reset, and it reports full and empty. Enqueue and dequeue each have their own round-robin arbiter, so two clients that push, or two that pop, in the same cycle are served one per cycle in turn. Head reads need no arbiter. Every client sees the same oldest entry, and reading it does not remove it. Depth and data width are parameters. Occupancy comes from read and write pointers that each carry one extra wrap bit.

Top module: `dual_client_fifo`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every enqueue ready is high and every dequeue ready and head-read ready is low.
- R2: Entries leave in the order they were accepted. While the store is not empty, head_data shows the oldest entry. That value does not change in any cycle without an accepted dequeue, whatever the head-read enables do.
- R3: Enqueue ready is low for every client once DEPTH entries are held (full), and high for at least one client whenever fewer are held.
- R4: Dequeue ready and head-read ready are low for every client when the store is empty. Head-read ready is high for every client when it is not empty.
- R5: At most one enqueue and at most one dequeue is accepted per cycle. When another client's enable for the same method is granted, a client's ready for that method is low in that cycle.
- R6: The enqueue grant goes to the first enabled client at or after a rotating pointer. The pointer starts at client 0 after reset and moves to the client after the winner on every accepted enqueue. With two clients that both enable in two successive cycles, client 0 wins the first cycle and client 1 wins the second.
- R7: Dequeue uses a separate rotating pointer with the same rule as R6. Enqueue traffic does not affect it.
- R8: An accepted enqueue and an accepted dequeue in the same cycle both take effect, and the occupancy stays the same.
- R9: An enable raised while its ready is low has no effect. Enqueue while full does not change the contents, and dequeue while empty does not change the contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enq_en | input | NUM_CLIENTS | Per-client enqueue enable |
| enq_data | input | NUM_CLIENTS x DATA_W | Per-client enqueue data |
| enq_rdy | output | NUM_CLIENTS | Per-client enqueue ready |
| deq_en | input | NUM_CLIENTS | Per-client dequeue enable |
| deq_rdy | output | NUM_CLIENTS | Per-client dequeue ready |
| head_rdy | output | NUM_CLIENTS | Per-client head-read ready |
| head_data | output | DATA_W | Oldest stored entry, shared by all clients |

## Verification
Directed patterns use a single client to fill the store to capacity and then drain it. This separates the full and empty guards from the arbitration. Two clients pushing together, and two popping together, in back-to-back cycles show whether the enqueue and dequeue pointers rotate, and whether they rotate independently of each other. Enables raised while the store is full or empty, and paired push-and-pop cycles near full, tell ignored requests apart from occupancy errors. A long seeded random phase with independently biased enables then compares ready and head values against a bench queue model every cycle.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   // width of an index able to name n items (at least one bit)
   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // true when n is a power of two
   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

   // method kinds, used to label arbiter instances
   typedef enum logic [1:0] {
      M_PUSH = 2'd0,
      M_POP  = 2'd1,
      M_PEEK = 2'd2
   } method_e;
endpackage

// File: rtl/dcf_store.sv
module dcf_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   localparam int AW    = $clog2(DEPTH),
   localparam int PW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_n,
   input  logic              pop_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              full,
   output logic              empty,
   output logic [PW-1:0]     occ
);
   logic [PW-1:0]     wp_q, rp_q;
   logic [DATA_W-1:0] mem [DEPTH];
   logic              do_push, do_pop;

   // pointers are equal in their low bits when full or empty; the wrap bit tells which
   assign empty   = (wp_q == rp_q);
   assign full    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
   assign occ     = wp_q - rp_q;
   assign do_push = !push_n && !full;
   assign do_pop  = !pop_n && !empty;
   assign rdata   = mem[rp_q[AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q <= '0;
         rp_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + PW'(1);
         if (do_pop)  rp_q <= rp_q + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp_q[AW-1:0]] <= wdata;
   end
endmodule

// File: rtl/dcf_rr_arb.sv
module dcf_rr_arb #(
   parameter int             N    = 2,
   parameter dcf_pkg::method_e KIND = dcf_pkg::M_PUSH,
   localparam int            IW   = dcf_pkg::idx_w(N)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] win
);
   logic [IW-1:0] ptr_q;
   logic          found;

   // scan from the pointer upward, wrapping, first requester wins
   always_comb begin
      gnt   = '0;
      win   = '0;
      found = 1'b0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(ptr_q) + k) % N;
         if (!found && req[j]) begin
            gnt[j] = 1'b1;
            win    = IW'(j);
            found  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv) begin
         ptr_q <= (int'(win) == N - 1) ? '0 : win + IW'(1);
      end
   end

   if (KIND == dcf_pkg::M_PEEK) begin : g_bad_kind
      $error("head reads are not arbitrated");
   end
endmodule

// File: rtl/dcf_guard.sv
module dcf_guard #(
   parameter int N = 2
) (
   input  logic         avail,
   input  logic [N-1:0] gnt,
   output logic [N-1:0] rdy,
   output logic         fire
);
   // a client is ready unless the method is unavailable or another client holds the grant
   for (genvar i = 0; i < N; i++) begin : g_cli
      logic [N-1:0] others;
      always_comb begin
         others    = gnt;
         others[i] = 1'b0;
      end
      assign rdy[i] = avail && !(|others);
   end

   assign fire = avail && (|gnt);
endmodule

// File: rtl/dual_client_fifo.sv
module dual_client_fifo #(
   parameter int NUM_CLIENTS = 2,
   parameter int DEPTH       = 8,
   parameter int DATA_W      = 32,
   localparam int IW         = dcf_pkg::idx_w(NUM_CLIENTS),
   localparam int PW         = $clog2(DEPTH) + 1
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [NUM_CLIENTS-1:0]              enq_en,
   input  logic [NUM_CLIENTS-1:0][DATA_W-1:0]  enq_data,
   output logic [NUM_CLIENTS-1:0]              enq_rdy,
   input  logic [NUM_CLIENTS-1:0]              deq_en,
   output logic [NUM_CLIENTS-1:0]              deq_rdy,
   output logic [NUM_CLIENTS-1:0]              head_rdy,
   output logic [DATA_W-1:0]                   head_data
);
   if (NUM_CLIENTS < 2) begin : g_bad_n
      $error("NUM_CLIENTS must be at least 2");
   end
   if (DEPTH < 2 || !dcf_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("DATA_W must be positive");
   end

   logic                   st_full, st_empty;
   logic [PW-1:0]          st_occ;
   logic [NUM_CLIENTS-1:0] push_gnt, pop_gnt;
   logic [IW-1:0]          push_win, pop_win;
   logic                   push_fire, pop_fire;
   logic [DATA_W-1:0]      push_word;

   dcf_rr_arb #(.N(NUM_CLIENTS), .KIND(dcf_pkg::M_PUSH)) u_push_arb (
      .clk (clk), .rst_n (rst_n), .req (enq_en), .adv (push_fire),
      .gnt (push_gnt), .win (push_win)
   );

   dcf_rr_arb #(.N(NUM_CLIENTS), .KIND(dcf_pkg::M_POP)) u_pop_arb (
      .clk (clk), .rst_n (rst_n), .req (deq_en), .adv (pop_fire),
      .gnt (pop_gnt), .win (pop_win)
   );

   dcf_guard #(.N(NUM_CLIENTS)) u_push_guard (
      .avail (!st_full), .gnt (push_gnt), .rdy (enq_rdy), .fire (push_fire)
   );

   dcf_guard #(.N(NUM_CLIENTS)) u_pop_guard (
      .avail (!st_empty), .gnt (pop_gnt), .rdy (deq_rdy), .fire (pop_fire)
   );

   // pop_win is only needed by the arbiter; keep it observed
   logic pop_win_unused;
   assign pop_win_unused = ^pop_win;

   assign push_word = enq_data[push_win];
   assign head_rdy  = {NUM_CLIENTS{!st_empty}};

   dcf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_n (!push_fire),
      .pop_n  (!pop_fire),
      .wdata  (push_word),
      .rdata  (head_data),
      .full   (st_full),
      .empty  (st_empty),
      .occ    (st_occ)
   );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk #(
   parameter int N      = 2,
   parameter int DEPTH  = 8,
   parameter int DATA_W = 32,
   localparam int PW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0]      enq_en,
   input logic [N-1:0]      enq_rdy,
   input logic [N-1:0]      deq_en,
   input logic [N-1:0]      deq_rdy,
   input logic [N-1:0]      head_rdy,
   input logic [DATA_W-1:0] head_data,
   input logic              st_full,
   input logic              st_empty,
   input logic [PW-1:0]     st_occ
);
   logic [N-1:0] ef, df;
   assign ef = enq_en & enq_rdy;
   assign df = deq_en & deq_rdy;

   // R3
   full_blocks_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_full |-> (enq_rdy == '0));
   // R4
   empty_blocks_deq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_empty |-> (deq_rdy == '0 && head_rdy == '0));
   // R5
   one_enq_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(ef));
   // R5
   one_deq_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(df));
   // R6
   enq_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_en[0] && enq_en[1] && ef[0]) |=> ((enq_en[0] && enq_en[1] && !st_full) |-> enq_rdy[1]));
   // R7
   deq_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deq_en[0] && deq_en[1] && df[0]) |=> ((deq_en[0] && deq_en[1] && !st_empty) |-> deq_rdy[1]));
   // R8
   occ_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|ef) && (|df)) |=> $stable(st_occ));
   // R9
   occ_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(|ef) && !(|df)) |=> $stable(st_occ));
   // R2
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_empty && !(|df)) |=> $stable(head_data));
endmodule

bind dual_client_fifo dcf_chk #(.N(NUM_CLIENTS), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .enq_en (enq_en), .enq_rdy (enq_rdy),
   .deq_en (deq_en), .deq_rdy (deq_rdy), .head_rdy (head_rdy), .head_data (head_data),
   .st_full (st_full), .st_empty (st_empty), .st_occ (st_occ)
);

// File: tb/sim_dual_client_fifo.sv
module sim_dual_client_fifo;
   localparam int D = 8;
   localparam int W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0]        enq_en = '0, deq_en = '0;
   logic [1:0][W-1:0] enq_data = '0;
   logic [1:0]        enq_rdy, deq_rdy, head_rdy;
   logic [W-1:0]      head_data;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [W-1:0] mq [D];
   int mh = 0, mcnt = 0, ep = 0, dp = 0;

   always #10 clk = ~clk;

   dual_client_fifo u0 (
      .clk (clk), .rst_n (rst_n), .enq_en (enq_en), .enq_data (enq_data),
      .enq_rdy (enq_rdy), .deq_en (deq_en), .deq_rdy (deq_rdy),
      .head_rdy (head_rdy), .head_data (head_data)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // pick the winner among requests given a rotating pointer; -1 when none
   function automatic int pick(input logic [1:0] r, input int p);
      if (r == 2'b11) return p;
      if (r[0]) return 0;
      if (r[1]) return 1;
      return -1;
   endfunction

   function automatic logic [1:0] exp_rdy(input bit blocked, input int w);
      if (blocked) return 2'b00;
      if (w < 0) return 2'b11;
      return 2'b01 << w;
   endfunction

   task automatic step(input string tag, input logic [1:0] ee, input logic [1:0] de,
                       input logic [W-1:0] d0, input logic [W-1:0] d1);
      int ew, dw;
      bit full, empty;
      @(negedge clk);
      enq_en = ee; deq_en = de; enq_data[0] = d0; enq_data[1] = d1;
      #2;
      full = (mcnt == D);
      empty = (mcnt == 0);
      ew = pick(ee, ep);
      dw = pick(de, dp);
      chk({tag, " enq_rdy"}, W'(enq_rdy), W'(exp_rdy(full, ew)));
      chk({tag, " deq_rdy"}, W'(deq_rdy), W'(exp_rdy(empty, dw)));
      chk({tag, " head_rdy"}, W'(head_rdy), empty ? '0 : W'(2'b11));
      if (!empty) chk({tag, " head_data"}, head_data, mq[mh]);
      if (!full && ew >= 0) begin
         mq[(mh + mcnt) % D] = (ew == 0) ? d0 : d1;
         ep = 1 - ew;
      end
      if (!empty && dw >= 0) begin
         mh = (mh + 1) % D;
         dp = 1 - dw;
      end
      mcnt = mcnt + ((!full && ew >= 0) ? 1 : 0) - ((!empty && dw >= 0) ? 1 : 0);
   endtask

   initial begin
      void'($urandom(32'd1357));
      #5;
      chk("R1 enq_rdy in reset", W'(enq_rdy), W'(2'b11));
      chk("R1 deq_rdy in reset", W'(deq_rdy), '0);
      chk("R1 head_rdy in reset", W'(head_rdy), '0);
      repeat (2) @(posedge clk);
      #3 rst_n = 1'b1;
      step("R1", 2'b00, 2'b00, '0, '0);

      // fill from client 0 alone
      for (int i = 0; i < D; i++) step("R3", 2'b01, 2'b00, W'(32'hA000 + i), '0);
      // enables while full are ignored
      step("R9", 2'b11, 2'b00, 32'hDEAD0000, 32'hDEAD0001);
      step("R9", 2'b10, 2'b00, 32'hDEAD0002, 32'hDEAD0003);
      // contended dequeues alternate
      step("R7", 2'b00, 2'b11, '0, '0);
      step("R7", 2'b00, 2'b11, '0, '0);
      step("R7", 2'b00, 2'b11, '0, '0);
      // push and pop together near full
      for (int i = 0; i < 4; i++) step("R8", 2'b10, 2'b01, '0, W'(32'hB000 + i));
      step("R8", 2'b01, 2'b00, W'(32'hB100), '0);
      step("R8", 2'b01, 2'b00, W'(32'hB101), '0);
      step("R3", 2'b01, 2'b00, W'(32'hB102), '0);
      // head reads with no pops leave the head alone, then drain
      step("R2", 2'b00, 2'b00, '0, '0);
      while (mcnt > 0) step("R2", 2'b00, 2'b10, '0, '0);
      // dequeue while empty is ignored
      step("R9", 2'b00, 2'b11, '0, '0);
      step("R4", 2'b00, 2'b00, '0, '0);
      // contended enqueues alternate
      for (int i = 0; i < 6; i++) step("R6", 2'b11, 2'b00, W'(32'hC000 + i), W'(32'hC100 + i));
      step("R6", 2'b10, 2'b00, '0, 32'hC200);
      while (mcnt > 0) step("R2", 2'b00, 2'b01, '0, '0);

      // seeded random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [1:0] ee, de;
         ee[0] = ($urandom % 100) < 45;
         ee[1] = ($urandom % 100) < 45;
         de[0] = ($urandom % 100) < 40;
         de[1] = ($urandom % 100) < 40;
         step("R5", ee, de, $urandom, $urandom);
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R1 actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule